// File: doc/BRIEF.md
# Two-Wire Configuration Target with Command-Selected Register Bank

This block is a target-only agent on a two-wire serial bus (I2C framing, 7-bit addressing). It runs in one system clock domain: the bus clock and data inputs are sampled through short synchronisers, and every bus event is detected from the sampled levels. Behind the bus sits an 8-bit command register and a set of configuration registers: a 3-bit operating mode, an 8-bit pipeline latency, eleven 8-bit bank slots (nine analogue bias settings and two test-pulse settings), and a read-only 2-bit fault status.

The command byte names a register in its upper seven bits and gives the transfer direction in its least significant bit. A store is one transfer: the address byte, a command byte with direction 0, and the value. A fetch takes two transfers. The first loads a command byte with direction 1. A later read transfer returns the chosen register, and it can be repeated without loading the command again. Four strap pins complete the device address. One shared chip code reaches every device at once. Because the data output only pulls low, a shared read returns the AND of all answers. The fault bits read 0 when set, so one shared read shows whether any device on the bus has a fault.

Top module: `cfg_i2c_target`

## Requirements
- R1: The device acknowledges an address byte only when its upper seven bits equal binary 001 followed by the inverted `strap_n` pins (`strap_n[3]` gives the highest chip bit). A pin held high therefore gives chip bit 0. Any other address gets no acknowledge, and the rest of that transfer has no effect.
- R2: The chip code 1111 (address 0x1F) is accepted by every device, for both stores and fetches. No device ever answers a fetch on it with a value other than its own register.
- R3: A store transfer is: address with R/W bit 0, a command byte with bit 0 clear, then a data byte, which is written into the selected register. The device acknowledges every byte it receives. Bytes after the data byte change nothing.
- R4: A transfer with command bit 0 set only loads the command register. A read transfer then returns the selected register MSB first. The controller acknowledges a byte to get it again, and later read transfers return the same register without a new command.
- R5: Command codes (bit 0 is the direction): 0x00/0x01 fault status, 0x02/0x03 mode, 0x04/0x05 latency, and 0x40+2k/0x41+2k for bank slot k (k = 0..10). Slot k appears on `bank_o[8k+7:8k]`.
- R6: The fault status reads as {6'b111111, ~fifo_flag, ~latency_flag}. A pulse on `fifo_fault` or `lat_fault` sets its flag. A flag stays set until `pipe_rst`. Stores to code 0x00 change nothing.
- R7: The mode register has bit 2 = calibration inhibit, bit 1 = peak processing (0 selects deconvolution), and bit 0 = bias enable. It comes up as 3'b100 after `rst_n`, `pipe_rst` leaves it unchanged, and it reads back with bits 7..3 as zero.
- R8: The latency register comes up as 0x84 after `rst_n` and can be stored to and read back freely.
- R9: A command code outside R5 is acknowledged and stores to it change nothing. A fetch of it returns 0xFF.
- R10: `sda_o` only pulls low (0) or releases (1). It is released while the device is idle and after the controller leaves a fetched byte unacknowledged.
- R11: A STOP (data rising while the bus clock is high) ends the transfer at any point. A store cut short this way writes nothing. A START (data falling while the bus clock is high) always begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low |
| pipe_rst | input | 1 | Pipeline reset pulse; clears fault flags only |
| fifo_fault | input | 1 | Pulse: queue overflow fault event |
| lat_fault | input | 1 | Pulse: pointer-separation fault event |
| strap_n | input | 4 | Inverted chip-address strap pins |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_o | output | 1 | Open-drain data drive: 0 pulls low, 1 releases |
| mode_o | output | 3 | Mode register |
| latency_o | output | 8 | Latency register |
| bank_o | output | 88 | Bank slots 0..10, slot k at bits 8k+7..8k |

## Verification
The bench sends addresses that differ from the true one only by the strap inversion. A design that used the straps without inverting them would acknowledge the wrong address and ignore the right one. Two devices with different register contents answer a shared fetch, and the bench checks for the bitwise AND. A design that drove high, or that ignored the shared code on reads, would return one device's byte instead. The bench also covers these cases: a pipeline reset that must clear the faults but keep the mode, stores to the read-only and unknown codes that must change no output, a STOP halfway through a data byte, and a trailing byte after the data. A design that wrote on a partial byte, or that treated the trailing byte as a new command, would show a changed register.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned SLOT_IDXW = 4;
  localparam logic [2:0]  DEV_PREFIX  = 3'b001;
  localparam logic [3:0]  SHARED_CHIP = 4'b1111;
  localparam logic [6:0]  BANK_BASE   = 7'h20;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK} link_st_e;
  typedef enum logic [2:0] {K_ERR, K_MODE, K_LAT, K_BANK, K_NONE} slot_kind_e;

  typedef struct packed {
    slot_kind_e           kind;
    logic [SLOT_IDXW-1:0] idx;
  } slot_t;

  function automatic logic addr_hit(input logic [6:0] a7, input logic [3:0] strap_n);
    return (a7 == {DEV_PREFIX, ~strap_n}) || (a7 == {DEV_PREFIX, SHARED_CHIP});
  endfunction

  function automatic slot_t decode_cmd(input logic [7:0] cmd, input int unsigned nbank);
    slot_t s;
    logic [6:0] c;
    c = cmd[7:1];
    s.kind = K_NONE;
    s.idx  = '0;
    if (c == 7'h00)      s.kind = K_ERR;
    else if (c == 7'h01) s.kind = K_MODE;
    else if (c == 7'h02) s.kind = K_LAT;
    else if (c >= BANK_BASE && c < BANK_BASE + 7'(nbank)) begin
      s.kind = K_BANK;
      s.idx  = SLOT_IDXW'(c - BANK_BASE);
    end
    return s;
  endfunction
endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES:0] scl_sh, sda_sh;
  logic scl_s, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign scl_p    = scl_sh[STAGES];
  assign sda_s    = sda_sh[STAGES-1];
  assign sda_p    = sda_sh[STAGES];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/cfg_i2c_link.sv
module cfg_i2c_link
  import cfg_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [3:0] strap_n,
  input  logic [7:0] rd_byte,
  output logic       sda_o,
  output logic       wr_cmd_stb,
  output logic       wr_data_stb,
  output logic [7:0] wr_byte
);
  link_st_e   st;
  logic [3:0] bit_cnt;
  logic [1:0] byte_idx;
  logic [7:0] rx_sh, tx_sh;
  logic       rd_mode;
  logic       addr_ok;
  logic       byte_end;

  assign addr_ok  = addr_hit(rx_sh[7:1], strap_n);
  assign byte_end = scl_fall && (bit_cnt == 4'd8);
  assign wr_byte  = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bit_cnt <= '0; byte_idx <= '0; rx_sh <= '0; tx_sh <= '0;
      rd_mode <= 1'b0; sda_o <= 1'b1; wr_cmd_stb <= 1'b0; wr_data_stb <= 1'b0;
    end else begin
      wr_cmd_stb  <= 1'b0;
      wr_data_stb <= 1'b0;
      if (stop_ev) begin
        st <= S_IDLE; sda_o <= 1'b1;
      end else if (start_ev) begin
        st <= S_RX; bit_cnt <= '0; byte_idx <= '0; rd_mode <= 1'b0; sda_o <= 1'b1;
      end else begin
        unique case (st)
          S_RX: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_end) begin
              if (byte_idx == 2'd0) begin
                if (addr_ok) begin
                  rd_mode <= rx_sh[0]; sda_o <= 1'b0; st <= S_RXACK;
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                sda_o       <= 1'b0;
                st          <= S_RXACK;
                wr_cmd_stb  <= (byte_idx == 2'd1);
                wr_data_stb <= (byte_idx == 2'd2);
              end
              if (byte_idx != 2'd3) byte_idx <= byte_idx + 2'd1;
            end
          end
          S_RXACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rd_mode) begin
                tx_sh <= rd_byte; sda_o <= rd_byte[7]; st <= S_TX;
              end else begin
                sda_o <= 1'b1; st <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_end) begin
              sda_o <= 1'b1; st <= S_TXACK;
            end else if (scl_fall) begin
              tx_sh <= {tx_sh[6:0], 1'b0}; sda_o <= tx_sh[6];
            end
          end
          S_TXACK: begin
            if (scl_rise) begin
              if (sda_s) st <= S_IDLE;
            end else if (scl_fall) begin
              bit_cnt <= '0; tx_sh <= rd_byte; sda_o <= rd_byte[7]; st <= S_TX;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> sda_o); // R10
  AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX && byte_idx == 2'd0 && byte_end && !addr_ok && !start_ev && !stop_ev) |=> sda_o); // R1
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (st == S_IDLE && sda_o)); // R11
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !stop_ev) |=> (st == S_RX && bit_cnt == 4'd0 && byte_idx == 2'd0)); // R11
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_cmd_stb && wr_data_stb)); // R3
endmodule

// File: rtl/cfg_i2c_regs.sv
module cfg_i2c_regs
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned NBANK    = 11,
  parameter logic [2:0]  MODE_RST = 3'b100,
  parameter logic [7:0]  LAT_RST  = 8'h84
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pipe_rst,
  input  logic                  fifo_fault,
  input  logic                  lat_fault,
  input  logic                  wr_cmd_stb,
  input  logic                  wr_data_stb,
  input  logic [7:0]            wr_byte,
  output logic [7:0]            rd_byte,
  output logic [2:0]            mode_q,
  output logic [7:0]            lat_q,
  output logic [NBANK-1:0][7:0] bank_q
);
  logic [7:0] cmd_q;
  logic [1:0] flag_q;
  slot_t      sel;
  logic       wr_ok, wr_mode, wr_lat, wr_bank;

  assign sel     = decode_cmd(cmd_q, NBANK);
  assign wr_ok   = wr_data_stb && !cmd_q[0];
  assign wr_mode = wr_ok && sel.kind == K_MODE;
  assign wr_lat  = wr_ok && sel.kind == K_LAT;
  assign wr_bank = wr_ok && sel.kind == K_BANK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; flag_q <= '0; mode_q <= MODE_RST; lat_q <= LAT_RST; bank_q <= '0;
    end else begin
      if (wr_cmd_stb) cmd_q <= wr_byte;
      flag_q <= (pipe_rst ? 2'b00 : flag_q) | {fifo_fault, lat_fault};
      if (wr_mode) mode_q <= wr_byte[2:0];
      if (wr_lat)  lat_q  <= wr_byte;
      for (int k = 0; k < int'(NBANK); k++)
        if (wr_bank && sel.idx == SLOT_IDXW'(k)) bank_q[k] <= wr_byte;
    end
  end

  always_comb begin
    unique case (sel.kind)
      K_ERR:   rd_byte = {6'h3F, ~flag_q};
      K_MODE:  rd_byte = {5'b0, mode_q};
      K_LAT:   rd_byte = lat_q;
      K_BANK:  rd_byte = bank_q[sel.idx];
      default: rd_byte = 8'hFF;
    endcase
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[1] && !pipe_rst) |=> flag_q[1]); // R6
  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(mode_q)); // R7
  AST_LAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lat |=> $stable(lat_q)); // R8
  AST_UNKNOWN_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_stb && sel.kind == K_NONE) |=> $stable(bank_q)); // R9
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned NBANK       = 11,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned BANK_W     = NBANK * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_rst,
  input  logic              fifo_fault,
  input  logic              lat_fault,
  input  logic [3:0]        strap_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic [2:0]        mode_o,
  output logic [7:0]        latency_o,
  output logic [BANK_W-1:0] bank_o
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic wr_cmd_stb, wr_data_stb;
  logic [7:0] wr_byte, rd_byte;
  logic [NBANK-1:0][7:0] bank_q;

  cfg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev));

  cfg_i2c_link u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .strap_n(strap_n), .rd_byte(rd_byte),
    .sda_o(sda_o), .wr_cmd_stb(wr_cmd_stb), .wr_data_stb(wr_data_stb), .wr_byte(wr_byte));

  cfg_i2c_regs #(.NBANK(NBANK)) u_regs (
    .clk(clk), .rst_n(rst_n), .pipe_rst(pipe_rst), .fifo_fault(fifo_fault),
    .lat_fault(lat_fault), .wr_cmd_stb(wr_cmd_stb), .wr_data_stb(wr_data_stb),
    .wr_byte(wr_byte), .rd_byte(rd_byte), .mode_q(mode_o), .lat_q(latency_o),
    .bank_q(bank_q));

  for (genvar g = 0; g < int'(NBANK); g++) begin : g_flat
    assign bank_o[g*BYTE_W +: BYTE_W] = bank_q[g];
  end
endmodule

// File: tb/cfg_i2c_target_bench.sv
module cfg_i2c_target_bench;
  localparam int Q = 5;
  localparam logic [6:0] ADR_A = 7'h15;  // strap_n 1010 -> chip 0101
  localparam logic [6:0] ADR_B = 7'h1C;  // strap_n 0011 -> chip 1100
  localparam logic [6:0] ADR_G = 7'h1F;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pipe_rst = 1'b0, fifo_a = 1'b0, lat_a = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_a, sda_b, bus;
  logic [2:0] mode_a, mode_b;
  logic [7:0] lat_a_q, lat_b_q;
  logic [87:0] bank_a, bank_b;
  int checks = 0, fails = 0;
  logic [7:0] got;
  logic [7:0] exp_q[$];
  string tag_q[$];
  event rd_ev;

  always #5 clk = ~clk;
  assign bus = sda_m & sda_a & sda_b;

  cfg_i2c_target u_cfg_i2c_target (
    .clk(clk), .rst_n(rst_n), .pipe_rst(pipe_rst), .fifo_fault(fifo_a), .lat_fault(lat_a),
    .strap_n(4'b1010), .scl_i(scl), .sda_i(bus), .sda_o(sda_a),
    .mode_o(mode_a), .latency_o(lat_a_q), .bank_o(bank_a));

  cfg_i2c_target u_peer (
    .clk(clk), .rst_n(rst_n), .pipe_rst(pipe_rst), .fifo_fault(1'b0), .lat_fault(1'b0),
    .strap_n(4'b0011), .scl_i(scl), .sda_i(bus), .sda_o(sda_b),
    .mode_o(mode_b), .latency_o(lat_b_q), .bank_o(bank_b));

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected bytes as fetched bytes arrive
  always begin
    @(rd_ev);
    if (exp_q.size() == 0) chk(1'b0, "R4 unexpected fetched byte", {24'b0, got}, 32'h0);
    else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(got === e, t, {24'b0, got}, {24'b0, e});
    end
  end

  task automatic expect_rd(input logic [7:0] v, input string tag);
    exp_q.push_back(v); tag_q.push_back(tag);
  endtask

  task automatic tick(input int n); repeat (n) @(posedge clk); #1; endtask
  task automatic send_bit(input logic b); sda_m = b; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q); endtask
  task automatic get_bit(output logic b); sda_m = 1; tick(Q); scl = 1; tick(Q); b = bus; tick(Q); scl = 0; tick(Q); endtask
  task automatic do_start; sda_m = 1; scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q); endtask
  task automatic do_stop; sda_m = 0; tick(Q); scl = 1; tick(Q); sda_m = 1; tick(2*Q); endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(b); ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic last);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    send_bit(last);
  endtask

  task automatic wr_xfer(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                         input int nextra, output logic aa, output logic ad);
    logic k;
    do_start; send_byte({a, 1'b0}, aa); send_byte(c, k); send_byte(d, ad);
    for (int i = 0; i < nextra; i++) send_byte(8'h99, k);
    do_stop;
  endtask

  task automatic set_cmd(input logic [6:0] a, input logic [7:0] c);
    logic k;
    do_start; send_byte({a, 1'b0}, k); send_byte(c, k); do_stop;
  endtask

  task automatic rd_xfer(input logic [6:0] a, input int n, output logic aa);
    logic [7:0] v;
    do_start; send_byte({a, 1'b1}, aa);
    if (aa) for (int i = 0; i < n; i++) begin
      recv_byte(v, i == n - 1); got = v; -> rd_ev; #1;
    end
    do_stop;
  endtask

  function automatic logic [7:0] slot(input logic [87:0] b, input int k); return b[8*k +: 8]; endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic aa, ad;
    logic [87:0] snap;
    tick(4); rst_n = 1; tick(4);
    // reset state
    chk(mode_a === 3'b100, "R7 mode after reset", {29'b0, mode_a}, 32'h4);
    chk(lat_a_q === 8'h84, "R8 latency after reset", {24'b0, lat_a_q}, 32'h84);
    chk(bank_a === '0, "R5 bank after reset", bank_a[31:0], 0);
    chk(sda_a === 1'b1, "R10 released when idle", {31'b0, sda_a}, 1);

    wr_xfer(ADR_A, 8'h40, 8'h7D, 0, aa, ad);
    chk(aa === 1'b1, "R1 address ack with inverted straps", {31'b0, aa}, 1);
    chk(slot(bank_a, 0) === 8'h7D, "R3 store slot 0", {24'b0, slot(bank_a, 0)}, 32'h7D);
    chk(slot(bank_b, 0) === 8'h00, "R1 peer untouched", {24'b0, slot(bank_b, 0)}, 0);

    wr_xfer(7'h1A, 8'h40, 8'h11, 0, aa, ad);  // straps used without inversion
    chk(aa === 1'b0, "R1 no ack on non-inverted strap address", {31'b0, aa}, 0);
    chk(slot(bank_a, 0) === 8'h7D, "R1 mismatch writes nothing", {24'b0, slot(bank_a, 0)}, 32'h7D);

    wr_xfer(ADR_A, 8'h4E, 8'h33, 1, aa, ad);
    chk(slot(bank_a, 7) === 8'h33, "R3 store with trailing byte", {24'b0, slot(bank_a, 7)}, 32'h33);
    chk(slot(bank_a, 0) === 8'h7D && mode_a === 3'b100, "R3 trailing byte ignored",
        {24'b0, slot(bank_a, 0)}, 32'h7D);

    set_cmd(ADR_A, 8'h41);
    expect_rd(8'h7D, "R4 fetch slot 0");
    rd_xfer(ADR_A, 1, aa);
    expect_rd(8'h7D, "R4 repeat fetch byte 1"); expect_rd(8'h7D, "R4 repeat fetch byte 2");
    rd_xfer(ADR_A, 2, aa);
    chk(sda_a === 1'b1, "R10 released after NACK", {31'b0, sda_a}, 1);

    wr_xfer(ADR_A, 8'h04, 8'h9C, 0, aa, ad);
    chk(lat_a_q === 8'h9C, "R8 latency store", {24'b0, lat_a_q}, 32'h9C);
    set_cmd(ADR_A, 8'h05); expect_rd(8'h9C, "R5 latency fetch"); rd_xfer(ADR_A, 1, aa);

    wr_xfer(ADR_A, 8'h02, 8'hFB, 0, aa, ad);
    chk(mode_a === 3'b011, "R7 mode store", {29'b0, mode_a}, 3);
    pipe_rst = 1; tick(1); pipe_rst = 0; tick(2);
    chk(mode_a === 3'b011, "R7 mode kept over pipeline reset", {29'b0, mode_a}, 3);
    set_cmd(ADR_A, 8'h03); expect_rd(8'h03, "R7 mode readback"); rd_xfer(ADR_A, 1, aa);

    set_cmd(ADR_A, 8'h01);
    expect_rd(8'hFF, "R6 no faults"); rd_xfer(ADR_A, 1, aa);
    fifo_a = 1; tick(1); fifo_a = 0; tick(2);
    expect_rd(8'hFD, "R6 fifo fault bit1 low"); rd_xfer(ADR_A, 1, aa);
    lat_a = 1; tick(1); lat_a = 0; tick(2);
    wr_xfer(ADR_A, 8'h00, 8'hFF, 0, aa, ad);
    set_cmd(ADR_A, 8'h01);
    expect_rd(8'hFC, "R6 both faults, store ignored"); rd_xfer(ADR_A, 1, aa);
    pipe_rst = 1; tick(1); pipe_rst = 0; tick(2);
    expect_rd(8'hFF, "R6 cleared by pipeline reset"); rd_xfer(ADR_A, 1, aa);

    wr_xfer(ADR_G, 8'h54, 8'hA5, 0, aa, ad);
    chk(aa === 1'b1 && slot(bank_a, 10) === 8'hA5 && slot(bank_b, 10) === 8'hA5,
        "R2 shared store reaches both", {24'b0, slot(bank_b, 10)}, 32'hA5);

    wr_xfer(ADR_A, 8'h44, 8'hF0, 0, aa, ad);
    wr_xfer(ADR_B, 8'h44, 8'h3C, 0, aa, ad);
    chk(slot(bank_b, 2) === 8'h3C, "R1 peer own address", {24'b0, slot(bank_b, 2)}, 32'h3C);
    set_cmd(ADR_G, 8'h45);
    expect_rd(8'h30, "R2 R10 shared fetch is wire-AND"); rd_xfer(ADR_G, 1, aa);

    snap = bank_a;
    wr_xfer(ADR_A, 8'h60, 8'h11, 0, aa, ad);
    chk(ad === 1'b1, "R9 unknown code acknowledged", {31'b0, ad}, 1);
    chk(bank_a === snap && lat_a_q === 8'h9C && mode_a === 3'b011, "R9 unknown store no effect",
        bank_a[31:0], snap[31:0]);
    set_cmd(ADR_A, 8'h61); expect_rd(8'hFF, "R9 unknown fetch"); rd_xfer(ADR_A, 1, aa);

    do_start; send_byte({ADR_A, 1'b0}, aa); send_byte(8'h48, aa);
    send_bit(1); send_bit(0); send_bit(1); send_bit(0); do_stop;
    chk(slot(bank_a, 4) === 8'h00, "R11 STOP mid-byte writes nothing", {24'b0, slot(bank_a, 4)}, 0);
    wr_xfer(ADR_A, 8'h48, 8'h53, 0, aa, ad);
    chk(slot(bank_a, 4) === 8'h53, "R11 next START works", {24'b0, slot(bank_a, 4)}, 32'h53);

    tick(4);
    chk(exp_q.size() == 0, "R4 all expected bytes fetched", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule